// File: doc/BRIEF.md
# Protection Entry CSR Write Controller

This block owns the control-register state for a bank of memory-protection entries: one configuration byte and one address register per entry, plus a three-bit security-configuration register. It gates every software write through the acceptance rules for those registers. These rules are the entry lock and its bypass, the reserved write-without-read encoding, the sticky security bits and the guard that a locked top-of-range neighbour places on an address register. Only writes that really change a stored value count as modifications.

A control-register write port carries a register kind, a register index, 64 bits of data and a width mode (32-bit or 64-bit). A combinational read port returns any register. The stored values drive a separate range decoder and access checker through flat output buses. A registered per-entry strobe tells that decoder which entries to recompute. A registered flush request tells the translation cache that permissions may have changed. A single-cycle unlock-all input strips the lock bit and the address mode from every entry.

Top module: `prot_csr_ctrl`

## Requirements
- R1: Register kind 0 selects configuration, 1 selects address and 2 selects security configuration. A configuration register r carries the byte of entry r*4+i in data bits [8i+7:8i]. Bytes i=0..3 are used in 32-bit mode and i=0..7 in 64-bit mode. The other bytes are not written, and reads pack the same entries in the same order. In 32-bit mode the upper half of the read data is zero.
- R2: The configuration byte layout is R=bit0, W=bit1, X=bit2, address mode=bits4:3 (0 off, 1 top-of-range, 2 aligned 4-byte, 3 aligned power-of-two) and lock=bit7. A byte write to an entry whose lock bit is set is dropped.
- R3: With the enhanced-security option enabled and the bypass bit (security bit 2) set, the lock bit no longer blocks configuration or address writes to that entry.
- R4: A configuration byte with W=1 and R=0 is dropped unless the lockdown bit (security bit 0) is set.
- R5: A configuration byte is stored only when it differs from the stored one. Each stored change raises that entry's change strobe and the flush request on the cycle after the write. An unchanged byte raises neither.
- R6: An address write to entry k is dropped while entry k+1 has its lock bit set and top-of-range mode, even when the bypass bit is set.
- R7: An address write to an entry whose lock is in force is dropped. An accepted address write that changes the value raises that entry's strobe and the flush request one cycle later. It also raises the next entry's strobe when that entry is in top-of-range mode.
- R8: The whitelist (bit 1) and lockdown (bit 0) security bits, once set, stay set until reset, and the bypass bit follows each write. A security write raises the flush request only when whitelist or lockdown changes.
- R9: With the enhanced-security option disabled, all three security bits stay zero, so lock bypass and the W-only relaxation never apply.
- R10: An unlock-all pulse clears the lock bit and the address-mode field of every entry and takes precedence over a configuration write in the same cycle. Entries it changes raise their strobes and the flush request.
- R11: Configuration bytes and address writes that address an entry index at or beyond the implemented count have no effect.
- R12: After reset every configuration byte, address register and security bit is zero, and no strobe or flush request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register kind: 0 configuration, 1 address, 2 security |
| wr_idx | input | IDX_W | Register index |
| wr_data | input | 64 | Write data |
| mode64 | input | 1 | 1 selects 64-bit register width, 0 selects 32-bit |
| unlock_all | input | 1 | Clear lock and address mode of all entries |
| rd_sel | input | 2 | Read register kind |
| rd_idx | input | IDX_W | Read register index |
| rd_data | output | 64 | Combinational read data |
| cfg_out | output | N_ENTRIES*8 | Configuration bytes, entry e at bits [8e+7:8e] |
| addr_out | output | N_ENTRIES*AW | Address registers, entry e at bits [AW*e+AW-1:AW*e] |
| rule_chg | output | N_ENTRIES | Per-entry range-recompute strobe |
| flush_req | output | 1 | Translation flush request |
| sec_out | output | 3 | Security bits: bypass, whitelist, lockdown |

## Verification
Several rules are checked on every cycle. The assertions cover entry 0: a locked configuration byte holds, and any change of it comes with its strobe. They also check that every strobe comes with a flush, that the sticky security bits never fall and that unlock-all leaves no lock or mode behind. Another assertion checks that a write into entry 0's address is held off while entry 1 is a locked top-of-range entry, and a further one checks that the security bits stay zero when the option is off. Only the directed scenarios can show the byte-to-entry mapping in both widths and exact strobe patterns, including the neighbour strobe. The same applies to the W-only encoding relaxed by lockdown, bypass unlocking an entry without lifting the neighbour guard, and silent out-of-range writes.

// File: rtl/prot_csr_pkg.sv
package prot_csr_pkg;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_SEC  = 2'd2
    } csr_sel_e;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     am;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    localparam int SEC_LD = 0;
    localparam int SEC_WL = 1;
    localparam int SEC_BP = 2;

    function automatic logic cfg_reserved(cfg_t c);
        return c.w && !c.r;
    endfunction

    function automatic cfg_t cfg_unlocked(cfg_t c);
        cfg_t o;
        o      = c;
        o.lock = 1'b0;
        o.am   = AM_OFF;
        return o;
    endfunction

    function automatic logic cfg_guards_prev(cfg_t c);
        return c.lock && (c.am == AM_TOR);
    endfunction

endpackage

// File: rtl/prot_cfg_lane.sv
module prot_cfg_lane
    import prot_csr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  cfg_t wr_val,
    input  logic bypass,
    input  logic lockdown,
    input  logic unlock_all,
    output cfg_t cfg_q,
    output logic chg_q
);
    cfg_t nxt;
    logic held;

    assign held = cfg_q.lock && !bypass;

    always_comb begin
        nxt = cfg_q;
        if (unlock_all)
            nxt = cfg_unlocked(cfg_q);
        else if (wr_hit && !held && !(cfg_reserved(wr_val) && !lockdown))
            nxt = wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            chg_q <= 1'b0;
        end else begin
            cfg_q <= nxt;
            chg_q <= (nxt != cfg_q);
        end
    end
endmodule

// File: rtl/prot_addr_lane.sv
module prot_addr_lane #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic [AW-1:0] wr_val,
    input  logic          self_held,
    input  logic          next_guard,
    input  logic          next_tor,
    output logic [AW-1:0] addr_q,
    output logic          chg_q,
    output logic          chg_next_q
);
    logic take;

    assign take = wr_hit && !self_held && !next_guard && (wr_val != addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            chg_q      <= 1'b0;
            chg_next_q <= 1'b0;
        end else begin
            if (take) addr_q <= wr_val;
            chg_q      <= take;
            chg_next_q <= take && next_tor;
        end
    end
endmodule

// File: rtl/prot_sec_reg.sv
module prot_sec_reg
    import prot_csr_pkg::*;
#(
    parameter bit ENH = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [2:0] wr_val,
    output logic [2:0] sec_q,
    output logic       flush_q
);
    logic [2:0] nxt;
    logic [2:0] sticky;

    assign sticky = sec_q & ((3'b1 << SEC_LD) | (3'b1 << SEC_WL));

    generate
        if (ENH) begin : g_enh
            assign nxt = wr ? (wr_val | sticky) : sec_q;
        end else begin : g_plain
            assign nxt = 3'b000;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            sec_q   <= nxt;
            flush_q <= (nxt[SEC_LD] != sec_q[SEC_LD]) || (nxt[SEC_WL] != sec_q[SEC_WL]);
        end
    end
endmodule

// File: rtl/prot_csr_ctrl.sv
module prot_csr_ctrl
    import prot_csr_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int AW        = 32,
    parameter int IDX_W     = 8,
    parameter bit ENH       = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [63:0]             wr_data,
    input  logic                    mode64,
    input  logic                    unlock_all,
    input  logic [1:0]              rd_sel,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [63:0]             rd_data,
    output logic [N_ENTRIES*8-1:0]  cfg_out,
    output logic [N_ENTRIES*AW-1:0] addr_out,
    output logic [N_ENTRIES-1:0]    rule_chg,
    output logic                    flush_req,
    output logic [2:0]              sec_out
);
    localparam int BW = IDX_W + 3;

    cfg_t                 cfg_q  [N_ENTRIES];
    logic [AW-1:0]        addr_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] cfg_chg, addr_chg, addr_chg_nx;
    logic [2:0]           sec_q;
    logic                 sec_flush;
    logic [BW-1:0]        wbase, rbase, nbytes;

    assign wbase  = BW'({wr_idx, 2'b00});
    assign rbase  = BW'({rd_idx, 2'b00});
    assign nbytes = mode64 ? BW'(8) : BW'(4);

    prot_sec_reg #(.ENH(ENH)) sec_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_en && (wr_sel == SEL_SEC)),
        .wr_val  (wr_data[2:0]),
        .sec_q   (sec_q),
        .flush_q (sec_flush)
    );

    generate
        for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
            localparam logic [BW-1:0] EV = BW'(e);
            logic [BW-1:0] off;
            logic          cfg_hit, addr_hit, guard, tor;

            assign off      = EV - wbase;
            assign cfg_hit  = wr_en && (wr_sel == SEL_CFG) && (EV >= wbase) && (off < nbytes);
            assign addr_hit = wr_en && (wr_sel == SEL_ADDR) && (wr_idx == IDX_W'(e));

            if (e < N_ENTRIES - 1) begin : g_nx
                assign guard = cfg_guards_prev(cfg_q[e+1]);
                assign tor   = (cfg_q[e+1].am == AM_TOR);
            end else begin : g_last
                assign guard = 1'b0;
                assign tor   = 1'b0;
            end

            prot_cfg_lane cfg_i (
                .clk        (clk),
                .rst        (rst),
                .wr_hit     (cfg_hit),
                .wr_val     (cfg_t'(wr_data[{off[2:0], 3'b000} +: 8])),
                .bypass     (sec_q[SEC_BP]),
                .lockdown   (sec_q[SEC_LD]),
                .unlock_all (unlock_all),
                .cfg_q      (cfg_q[e]),
                .chg_q      (cfg_chg[e])
            );

            prot_addr_lane #(.AW(AW)) addr_i (
                .clk        (clk),
                .rst        (rst),
                .wr_hit     (addr_hit),
                .wr_val     (wr_data[AW-1:0]),
                .self_held  (cfg_q[e].lock && !sec_q[SEC_BP]),
                .next_guard (guard),
                .next_tor   (tor),
                .addr_q     (addr_q[e]),
                .chg_q      (addr_chg[e]),
                .chg_next_q (addr_chg_nx[e])
            );

            assign cfg_out[e*8 +: 8]   = cfg_q[e];
            assign addr_out[e*AW +: AW] = addr_q[e];
        end
    endgenerate

    assign rule_chg  = cfg_chg | addr_chg | {addr_chg_nx[N_ENTRIES-2:0], 1'b0};
    assign flush_req = (|cfg_chg) || (|addr_chg) || sec_flush;
    assign sec_out   = sec_q;

    always_comb begin
        logic [BW-1:0] roff;
        rd_data = '0;
        unique case (rd_sel)
            SEL_CFG: begin
                for (int e = 0; e < N_ENTRIES; e++) begin
                    roff = BW'(e) - rbase;
                    if ((BW'(e) >= rbase) && (roff < nbytes))
                        rd_data = rd_data | (64'(cfg_q[e]) << {roff[2:0], 3'b000});
                end
            end
            SEL_ADDR: begin
                for (int e = 0; e < N_ENTRIES; e++)
                    if (rd_idx == IDX_W'(e)) rd_data = 64'(addr_q[e]);
            end
            SEL_SEC:  rd_data = 64'(sec_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/prot_csr_ctrl_chk.sv
module prot_csr_ctrl_chk #(
    parameter int N_ENTRIES = 16,
    parameter int AW        = 32,
    parameter int IDX_W     = 8,
    parameter bit ENH       = 1'b1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic [IDX_W-1:0]        wr_idx,
    input logic                    unlock_all,
    input logic [N_ENTRIES*8-1:0]  cfg_out,
    input logic [N_ENTRIES*AW-1:0] addr_out,
    input logic [N_ENTRIES-1:0]    rule_chg,
    input logic                    flush_req,
    input logic [2:0]              sec_out
);
    a_r5_strobe_flush: assert property (@(posedge clk) disable iff (rst)
        (rule_chg != '0) |-> flush_req);

    a_r5_change_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_out[7:0]) |-> rule_chg[0]);

    a_r2_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (cfg_out[7] && !sec_out[2] && !unlock_all) |=> $stable(cfg_out[7:0]));

    a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (rst)
        sec_out[0] |=> sec_out[0]);

    a_r8_whitelist_sticky: assert property (@(posedge clk) disable iff (rst)
        sec_out[1] |=> sec_out[1]);

    a_r6_tor_guard: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 2'd1) && (wr_idx == '0) && cfg_out[15] && (cfg_out[12:11] == 2'b01))
        |=> $stable(addr_out[AW-1:0]));

    a_r10_unlock_clears: assert property (@(posedge clk) disable iff (rst)
        unlock_all |=> (!cfg_out[7] && (cfg_out[4:3] == 2'b00)));

    generate
        if (!ENH) begin : g_plain
            a_r9_sec_zero: assert property (@(posedge clk) disable iff (rst)
                wr_en |=> (sec_out == 3'b000));
        end
    endgenerate
endmodule

bind prot_csr_ctrl prot_csr_ctrl_chk #(
    .N_ENTRIES (N_ENTRIES),
    .AW        (AW),
    .IDX_W     (IDX_W),
    .ENH       (ENH)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_idx     (wr_idx),
    .unlock_all (unlock_all),
    .cfg_out    (cfg_out),
    .addr_out   (addr_out),
    .rule_chg   (rule_chg),
    .flush_req  (flush_req),
    .sec_out    (sec_out)
);

// File: tb/prot_csr_ctrl_tb_top.sv
module prot_csr_ctrl_tb_top;
    localparam int N  = 16;
    localparam int AW = 32;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [IW-1:0] wr_idx = '0;
    logic [63:0]   wr_data = '0;
    logic          mode64 = 1'b0;
    logic          unlock_all = 1'b0;
    logic [1:0]    rd_sel = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [63:0]   rd_data, rd_data_ne;
    logic [N*8-1:0]  cfg_out, cfg_out_ne;
    logic [N*AW-1:0] addr_out, addr_out_ne;
    logic [N-1:0]  rule_chg, rule_chg_ne;
    logic          flush_req, flush_ne;
    logic [2:0]    sec_out, sec_out_ne;

    int n_chk = 0;
    int n_fail = 0;
    logic [N-1:0] got_chg;
    logic         got_fl;
    logic [63:0]  rv;

    always #5 clk = ~clk;

    prot_csr_ctrl #(.N_ENTRIES(N), .AW(AW), .IDX_W(IW), .ENH(1'b1)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .mode64(mode64), .unlock_all(unlock_all),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data), .cfg_out(cfg_out),
        .addr_out(addr_out), .rule_chg(rule_chg), .flush_req(flush_req), .sec_out(sec_out));

    prot_csr_ctrl #(.N_ENTRIES(N), .AW(AW), .IDX_W(IW), .ENH(1'b0)) dut_ne (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .mode64(mode64), .unlock_all(unlock_all),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data_ne), .cfg_out(cfg_out_ne),
        .addr_out(addr_out_ne), .rule_chg(rule_chg_ne), .flush_req(flush_ne), .sec_out(sec_out_ne));

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [IW-1:0] idx, logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        got_chg = rule_chg;
        got_fl  = flush_req;
    endtask

    task automatic rd(logic [1:0] sel, logic [IW-1:0] idx, output logic [63:0] d);
        rd_sel = sel; rd_idx = idx;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        check("R12", "cfg", 64'(cfg_out), 64'd0);
        check("R12", "addr", 64'(addr_out), 64'd0);
        check("R12", "strobe", 64'(rule_chg), 64'd0);
        check("R12", "flush", 64'(flush_req), 64'd0);
        rd(2'd2, '0, rv); check("R12", "sec", rv, 64'd0);
    endtask

    task automatic t_map;
        mode64 = 1'b0;
        wr(2'd0, 8'd1, 64'h0707_0707_0D09_0301);
        check("R1", "strobe 32b", 64'(got_chg), 64'h00F0);
        check("R5", "flush", 64'(got_fl), 64'd1);
        rd(2'd0, 8'd1, rv); check("R1", "read cfg1", rv, 64'h0D09_0301);
        rd(2'd0, 8'd2, rv); check("R1", "upper bytes unwritten", rv, 64'd0);
    endtask

    task automatic t_same;
        wr(2'd0, 8'd1, 64'h0D09_0301);
        check("R5", "same strobe", 64'(got_chg), 64'd0);
        check("R5", "same flush", 64'(got_fl), 64'd0);
        wr(2'd0, 8'd1, 64'h0D1F_0301);
        check("R5", "one byte strobe", 64'(got_chg), 64'h0040);
    endtask

    task automatic t_wonly;
        wr(2'd0, 8'd0, 64'h0000_0002);
        check("R4", "w-only strobe", 64'(got_chg), 64'd0);
        rd(2'd0, 8'd0, rv); check("R4", "w-only dropped", rv, 64'd0);
    endtask

    task automatic t_lock;
        wr(2'd0, 8'd0, 64'h0000_0883);
        check("R2", "lock set strobe", 64'(got_chg), 64'h0003);
        wr(2'd0, 8'd0, 64'h0000_0801);
        check("R2", "locked strobe", 64'(got_chg), 64'd0);
        rd(2'd0, 8'd0, rv); check("R2", "locked value", rv, 64'h0000_0883);
        wr(2'd1, 8'd0, 64'h0000_0044);
        check("R7", "locked addr strobe", 64'(got_chg), 64'd0);
        rd(2'd1, 8'd0, rv); check("R7", "locked addr", rv, 64'd0);
    endtask

    task automatic t_tor_guard;
        wr(2'd0, 8'd0, 64'h8800_0883);
        check("R2", "entry3 lock", 64'(got_chg), 64'h0008);
        wr(2'd1, 8'd2, 64'h0000_0055);
        check("R6", "guard strobe", 64'(got_chg), 64'd0);
        rd(2'd1, 8'd2, rv); check("R6", "guarded addr", rv, 64'd0);
    endtask

    task automatic t_addr;
        wr(2'd1, 8'd4, 64'h0000_1000);
        check("R7", "addr strobe", 64'(got_chg), 64'h0010);
        check("R7", "addr flush", 64'(got_fl), 64'd1);
        rd(2'd1, 8'd4, rv); check("R7", "addr value", rv, 64'h1000);
        wr(2'd0, 8'd1, 64'h0D1F_0801);
        check("R5", "tor set strobe", 64'(got_chg), 64'h0020);
        wr(2'd1, 8'd4, 64'h0000_2000);
        check("R7", "next tor strobe", 64'(got_chg), 64'h0030);
        wr(2'd1, 8'd4, 64'h0000_2000);
        check("R7", "same addr strobe", 64'(got_chg), 64'd0);
        check("R7", "same addr flush", 64'(got_fl), 64'd0);
    endtask

    task automatic t_range;
        mode64 = 1'b1;
        wr(2'd0, 8'd3, 64'h0101_0101_0101_0101);
        check("R11", "partial strobe", 64'(got_chg), 64'hF000);
        rd(2'd0, 8'd3, rv); check("R11", "read past end", rv, 64'h0000_0000_0101_0101);
        rd(2'd0, 8'd2, rv); check("R1", "read 64b", rv, 64'h0101_0101_0000_0000);
        wr(2'd1, 8'd20, 64'h0000_9999);
        check("R11", "addr oob strobe", 64'(got_chg), 64'd0);
        check("R11", "addr oob flush", 64'(got_fl), 64'd0);
        mode64 = 1'b0;
    endtask

    task automatic t_sec;
        wr(2'd2, '0, 64'h1);
        check("R8", "lockdown flush", 64'(got_fl), 64'd1);
        wr(2'd2, '0, 64'h0);
        check("R8", "lockdown flush none", 64'(got_fl), 64'd0);
        rd(2'd2, '0, rv); check("R8", "lockdown sticky", rv, 64'h1);
        wr(2'd0, 8'd0, 64'h8802_0883);
        check("R4", "w-only with lockdown", 64'(got_chg), 64'h0004);
        wr(2'd2, '0, 64'h4);
        check("R8", "bypass no flush", 64'(got_fl), 64'd0);
        rd(2'd2, '0, rv); check("R8", "bypass read", rv, 64'h5);
        wr(2'd0, 8'd0, 64'h8802_0801);
        check("R3", "bypass unlocks", 64'(got_chg), 64'h0001);
        wr(2'd1, 8'd2, 64'h0000_0077);
        check("R6", "guard despite bypass", 64'(got_chg), 64'd0);
        wr(2'd2, '0, 64'h2);
        check("R8", "whitelist flush", 64'(got_fl), 64'd1);
        rd(2'd2, '0, rv); check("R8", "bypass drops", rv, 64'h3);
    endtask

    task automatic t_unlock;
        @(negedge clk);
        unlock_all = 1'b1;
        wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 8'd2; wr_data = 64'h01;
        @(negedge clk);
        unlock_all = 1'b0; wr_en = 1'b0;
        got_chg = rule_chg; got_fl = flush_req;
        check("R10", "unlock strobe", 64'(got_chg), 64'h00EA);
        check("R10", "unlock flush", 64'(got_fl), 64'd1);
        rd(2'd0, 8'd0, rv); check("R10", "cfg0", rv, 64'h0002_0001);
        rd(2'd0, 8'd1, rv); check("R10", "cfg1", rv, 64'h0507_0001);
        rd(2'd0, 8'd2, rv); check("R10", "write loses", rv, 64'd0);
    endtask

    task automatic t_noenh;
        check("R9", "sec zero", 64'(sec_out_ne), 64'd0);
        check("R9", "w-only dropped", 64'(cfg_out_ne[23:16]), 64'd0);
        check("R9", "lock not bypassed", 64'(cfg_out_ne[7:0]), 64'h83);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_same();
        t_wonly();
        t_lock();
        t_tor_guard();
        t_addr();
        t_range();
        t_sec();
        t_noenh();
        t_unlock();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule